// File: doc/BRIEF.md
# Bit-Stuffing Frame Transmitter with Tagged Queue

This block turns bytes written by a controller into a serial bit stream for a modulator. Bytes enter a 32-deep queue whose entries are 10 bits wide. The low byte is payload, and two extra tag bits mark where a packet begins and where it ends. A serial engine drains the queue one bit per `bit_en` strobe.

In framed mode, a packet is sent as follows:

- an opening 0x7E flag;
- the payload, least significant bit first, with zero-insertion;
- a complemented check sequence from a CRC chosen at run time;
- a closing flag.

In raw mode the bytes are shifted out back to back, with no framing at all.

The queue reports its fill level, empty and full, and sticky overrun and underrun indications. A single flush command clears the queue and both sticky flags. A level-sensitive interrupt is the OR of five maskable queue conditions. It drops as soon as the condition that raised it goes away.

Top module: `hdlc_tx_framer`

## Requirements
- R1: The queue holds up to 32 entries. `fifo_count` gives the number of entries held (0 to 32). `fifo_empty` is high at count 0, and `fifo_full` is high at count 32.
- R2: A write while full is dropped and sets `ovr_flag`, which stays set. `flush` empties the queue and clears `ovr_flag` and `udr_flag`, and it takes priority over a write in the same cycle.
- R3: In framed mode, an idle engine discards queue entries whose begin tag (bit 8) is clear. An entry with bit 8 set starts a frame. Every frame opens with the flag 0x7E, sent LSB first.
- R4: Payload bytes are sent LSB first. The entry whose end tag (bit 9) is set carries the last payload byte. It is followed by the check sequence and then a closing 0x7E flag.
- R5: `crc_sel` chooses the check sequence, which is computed bit-serially in reflected form over the payload bits in send order:
  - 0 selects the 16-bit polynomial 0x1021 (reflected 0x8408);
  - 1 selects the 16-bit polynomial 0x8005 (reflected 0xA001);
  - 2 or 3 selects the 32-bit polynomial 0x04C11DB7 (reflected 0xEDB88320).
- R6: The CRC register starts from `crc_init`, using its low 16 bits for the 16-bit choices. The check sequence is the complemented register, sent LSB first.
- R7: After five consecutive 1s in the payload and check sequence, a 0 is inserted, including after the final five. No 0 is ever inserted inside a flag.
- R8: If the queue is empty when a byte without the end tag finishes, `udr_flag` is set. No check sequence is sent, and the frame is closed with a flag.
- R9: In raw mode every entry is sent as 8 bits, LSB first, back to back. No flag, check sequence or inserted 0 is sent, and both tags are ignored. An empty queue returns the engine to idle without setting `udr_flag`.
- R10: `tx_bit` and `tx_act` change only on a clock edge where `bit_en` is high. `tx_act` is high exactly when `tx_bit` carries a frame or raw bit.
- R11: `irq` is high when any enabled source is true. The sources, by `irq_mask` bit, are:
  - bit 0: empty;
  - bit 1: not empty;
  - bit 2: full;
  - bit 3: not full;
  - bit 4: count greater than or equal to `irq_thr`.
- R12: After reset the queue is empty, both sticky flags are clear, `tx_act` is low and `tx_bit` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one entry into the queue |
| wr_data | input | 10 | Entry: [7:0] byte, [8] begin tag, [9] end tag |
| flush | input | 1 | Empty queue and clear sticky flags |
| raw_mode | input | 1 | 1 = raw serialisation, 0 = framed |
| crc_sel | input | 2 | Check sequence choice |
| crc_init | input | 32 | CRC start value |
| irq_mask | input | 5 | Interrupt source enables |
| irq_thr | input | 6 | Fill-level threshold |
| bit_en | input | 1 | Advance the serial output by one bit |
| tx_bit | output | 1 | Serial data |
| tx_act | output | 1 | Serial data is part of a frame or raw stream |
| fifo_count | output | 6 | Entries held |
| fifo_empty | output | 1 | Queue empty |
| fifo_full | output | 1 | Queue full |
| ovr_flag | output | 1 | Sticky overrun |
| udr_flag | output | 1 | Sticky underrun |
| irq | output | 1 | Level interrupt |

## Verification
On every cycle, the assertions check these behaviours:
- the fill-level bound;
- that a flush leaves the queue empty with both flags clear;
- that overrun is set by a write into a full queue and then holds;
- that the serial outputs freeze while `bit_en` is low;
- that enabled empty and full conditions raise the interrupt.

The bit-level content of frames can only be shown by the bench's scenarios, which cover:
- flag placement, LSB-first order and zero-insertion;
- each CRC choice with differing start values;
- discarding of untagged entries, underrun termination and raw serialisation.

The bench compares the captured stream against a bit-exact model.

// File: rtl/hdlc_pkg.sv
package hdlc_pkg;

  localparam logic [7:0] FLAG_BYTE = 8'h7E;
  localparam int         TAG_BEGIN = 8;
  localparam int         TAG_END   = 9;
  localparam int         N_IRQ_SRC = 5;

  typedef enum logic [2:0] {
    S_IDLE,
    S_OFLAG,
    S_DATA,
    S_FCS,
    S_CFLAG
  } tx_state_e;

  // reflected polynomial for the chosen check sequence
  function automatic logic [31:0] crc_poly(input logic [1:0] sel);
    case (sel)
      2'd0:    return 32'h0000_8408;
      2'd1:    return 32'h0000_A001;
      default: return 32'hEDB8_8320;
    endcase
  endfunction

  function automatic logic is_crc16(input logic [1:0] sel);
    return (sel == 2'd0) || (sel == 2'd1);
  endfunction

  // index of the last check-sequence bit
  function automatic logic [4:0] fcs_last(input logic [1:0] sel);
    return is_crc16(sel) ? 5'd15 : 5'd31;
  endfunction

endpackage

// File: rtl/hdlc_fifo.sv
module hdlc_fifo #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 10,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    count,
  output logic             empty,
  output logic             full
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr, wr_n, rd_n;
  logic [CW-1:0]    cnt_n;
  logic             do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign head    = mem[rd_ptr];

  always_comb begin
    wr_n  = wr_ptr;
    rd_n  = rd_ptr;
    cnt_n = count;
    if (flush) begin
      wr_n  = '0;
      rd_n  = '0;
      cnt_n = '0;
    end else begin
      if (do_push) wr_n = wr_ptr + 1'b1;
      if (do_pop)  rd_n = rd_ptr + 1'b1;
      cnt_n = count + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_n;
      rd_ptr <= rd_n;
      count  <= cnt_n;
    end
  end

endmodule

// File: rtl/hdlc_crc.sv
module hdlc_crc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] init_val,
  input  logic [1:0]  sel,
  input  logic        shift_en,
  input  logic        din,
  input  logic        fcs_en,
  output logic        lsb
);
  import hdlc_pkg::*;

  logic [31:0] crc_q, crc_n;
  logic        fb;

  assign fb  = crc_q[0] ^ din;
  assign lsb = crc_q[0];

  always_comb begin
    crc_n = crc_q;
    if (load)
      crc_n = is_crc16(sel) ? {16'h0, init_val[15:0]} : init_val;
    else if (shift_en)
      crc_n = (crc_q >> 1) ^ (fb ? crc_poly(sel) : 32'h0);
    else if (fcs_en)
      crc_n = crc_q >> 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '1;
    else        crc_q <= crc_n;
  end

endmodule

// File: rtl/hdlc_irq.sv
module hdlc_irq #(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic                       empty,
  input  logic                       full,
  input  logic [CW-1:0]              count,
  input  logic [CW-1:0]              thr,
  input  logic [hdlc_pkg::N_IRQ_SRC-1:0] mask,
  output logic                       irq
);
  logic [hdlc_pkg::N_IRQ_SRC-1:0] src;

  assign src = {count >= thr, !full, full, !empty, empty};
  assign irq = |(src & mask);

endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer #(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [9:0]    wr_data,
  input  logic          flush,
  input  logic          raw_mode,
  input  logic [1:0]    crc_sel,
  input  logic [31:0]   crc_init,
  input  logic [4:0]    irq_mask,
  input  logic [CW-1:0] irq_thr,
  input  logic          bit_en,
  output logic          tx_bit,
  output logic          tx_act,
  output logic [CW-1:0] fifo_count,
  output logic          fifo_empty,
  output logic          fifo_full,
  output logic          ovr_flag,
  output logic          udr_flag,
  output logic          irq
);
  import hdlc_pkg::*;

  localparam logic [2:0] RUN_LIMIT = 3'd5;

  tx_state_e   state, state_n;
  logic [7:0]  sh, sh_n;
  logic        end_q, end_n;
  logic [4:0]  bitn, bitn_n;
  logic [2:0]  ones, ones_n;
  logic        raw_q, raw_n;
  logic [1:0]  sel_q, sel_n;
  logic        txb_n, act_n;
  logic        pop, udr_set;
  logic        crc_load, crc_shift, crc_fcs, crc_lsb;
  logic [9:0]  f_head;
  logic        stuff_due;

  hdlc_fifo #(.DEPTH(DEPTH), .WIDTH(10)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(wr_en), .push_data(wr_data),
    .pop(pop), .head(f_head), .count(fifo_count), .empty(fifo_empty), .full(fifo_full)
  );

  hdlc_crc u_crc (
    .clk(clk), .rst_n(rst_n), .load(crc_load), .init_val(crc_init), .sel(sel_n),
    .shift_en(crc_shift), .din(sh[0]), .fcs_en(crc_fcs), .lsb(crc_lsb)
  );

  hdlc_irq #(.DEPTH(DEPTH)) u_irq (
    .empty(fifo_empty), .full(fifo_full), .count(fifo_count), .thr(irq_thr),
    .mask(irq_mask), .irq(irq)
  );

  assign stuff_due = (ones == RUN_LIMIT);

  always_comb begin
    state_n   = state;
    sh_n      = sh;
    end_n     = end_q;
    bitn_n    = bitn;
    ones_n    = ones;
    raw_n     = raw_q;
    sel_n     = sel_q;
    txb_n     = tx_bit;
    act_n     = tx_act;
    pop       = 1'b0;
    udr_set   = 1'b0;
    crc_load  = 1'b0;
    crc_shift = 1'b0;
    crc_fcs   = 1'b0;
    if (bit_en) begin
      unique case (state)
        S_IDLE: begin
          txb_n = 1'b1;
          act_n = 1'b0;
          if (!fifo_empty) begin
            pop = 1'b1;
            if (raw_mode || f_head[TAG_BEGIN]) begin
              raw_n    = raw_mode;
              sel_n    = crc_sel;
              sh_n     = f_head[7:0];
              end_n    = f_head[TAG_END];
              crc_load = 1'b1;
              bitn_n   = '0;
              ones_n   = '0;
              state_n  = raw_mode ? S_DATA : S_OFLAG;
            end
          end
        end
        S_OFLAG: begin
          txb_n  = FLAG_BYTE[bitn[2:0]];
          act_n  = 1'b1;
          ones_n = '0;
          bitn_n = bitn + 5'd1;
          if (bitn == 5'd7) begin
            state_n = S_DATA;
            bitn_n  = '0;
          end
        end
        S_DATA: begin
          act_n = 1'b1;
          if (!raw_q && stuff_due) begin
            txb_n  = 1'b0;
            ones_n = '0;
          end else begin
            txb_n     = sh[0];
            sh_n      = {1'b0, sh[7:1]};
            crc_shift = !raw_q;
            ones_n    = sh[0] ? ones + 3'd1 : 3'd0;
            bitn_n    = bitn + 5'd1;
            if (bitn == 5'd7) begin
              bitn_n = '0;
              if (!raw_q && end_q) begin
                state_n = S_FCS;
              end else if (!fifo_empty) begin
                pop   = 1'b1;
                sh_n  = f_head[7:0];
                end_n = f_head[TAG_END];
              end else if (raw_q) begin
                state_n = S_IDLE;
              end else begin
                udr_set = 1'b1;
                state_n = S_CFLAG;
              end
            end
          end
        end
        S_FCS: begin
          act_n = 1'b1;
          if (stuff_due) begin
            txb_n  = 1'b0;
            ones_n = '0;
          end else begin
            txb_n   = ~crc_lsb;
            crc_fcs = 1'b1;
            ones_n  = crc_lsb ? 3'd0 : ones + 3'd1;
            bitn_n  = bitn + 5'd1;
            if (bitn == fcs_last(sel_q)) begin
              state_n = S_CFLAG;
              bitn_n  = '0;
            end
          end
        end
        S_CFLAG: begin
          act_n = 1'b1;
          if (stuff_due) begin
            txb_n  = 1'b0;
            ones_n = '0;
          end else begin
            txb_n  = FLAG_BYTE[bitn[2:0]];
            ones_n = '0;
            bitn_n = bitn + 5'd1;
            if (bitn == 5'd7) begin
              state_n = S_IDLE;
              bitn_n  = '0;
            end
          end
        end
        default: state_n = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      sh     <= '0;
      end_q  <= 1'b0;
      bitn   <= '0;
      ones   <= '0;
      raw_q  <= 1'b0;
      sel_q  <= '0;
      tx_bit <= 1'b1;
      tx_act <= 1'b0;
    end else if (bit_en) begin
      state  <= state_n;
      sh     <= sh_n;
      end_q  <= end_n;
      bitn   <= bitn_n;
      ones   <= ones_n;
      raw_q  <= raw_n;
      sel_q  <= sel_n;
      tx_bit <= txb_n;
      tx_act <= act_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_flag <= 1'b0;
      udr_flag <= 1'b0;
    end else if (flush) begin
      ovr_flag <= 1'b0;
      udr_flag <= 1'b0;
    end else begin
      if (wr_en && fifo_full) ovr_flag <= 1'b1;
      if (udr_set)            udr_flag <= 1'b1;
    end
  end

endmodule

// File: rtl/hdlc_tx_framer_chk.sv
module hdlc_tx_framer_chk #(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          flush,
  input logic          bit_en,
  input logic [4:0]    irq_mask,
  input logic          tx_bit,
  input logic          tx_act,
  input logic [CW-1:0] fifo_count,
  input logic          fifo_empty,
  input logic          fifo_full,
  input logic          ovr_flag,
  input logic          udr_flag,
  input logic          irq
);

  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CW'(DEPTH));

  assert_flush_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (fifo_count == '0) && !ovr_flag && !udr_flag);

  assert_overrun_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fifo_full && !flush) |=> ovr_flag);

  assert_overrun_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !flush) |=> ovr_flag);

  assert_underrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (udr_flag && !flush) |=> udr_flag);

  assert_hold_without_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(tx_bit) && $stable(tx_act));

  assert_irq_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask[0] && fifo_empty) |-> irq);

  assert_irq_full_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask[2] && fifo_full) |-> irq);

endmodule

bind hdlc_tx_framer hdlc_tx_framer_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .flush(flush), .bit_en(bit_en),
  .irq_mask(irq_mask), .tx_bit(tx_bit), .tx_act(tx_act), .fifo_count(fifo_count),
  .fifo_empty(fifo_empty), .fifo_full(fifo_full), .ovr_flag(ovr_flag),
  .udr_flag(udr_flag), .irq(irq)
);

// File: tb/hdlc_tx_framer_test.sv
module hdlc_tx_framer_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, flush, raw_mode, bit_en;
  logic [9:0]  wr_data;
  logic [1:0]  crc_sel;
  logic [31:0] crc_init;
  logic [4:0]  irq_mask;
  logic [5:0]  irq_thr;
  logic        tx_bit, tx_act, fifo_empty, fifo_full, ovr_flag, udr_flag, irq;
  logic [5:0]  fifo_count;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [7:0] pay [16];
  bit body_q[$];
  bit exp_q[$];
  bit cap_q[$];
  logic en_seen;

  hdlc_tx_framer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .flush(flush),
    .raw_mode(raw_mode), .crc_sel(crc_sel), .crc_init(crc_init), .irq_mask(irq_mask),
    .irq_thr(irq_thr), .bit_en(bit_en), .tx_bit(tx_bit), .tx_act(tx_act),
    .fifo_count(fifo_count), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .ovr_flag(ovr_flag), .udr_flag(udr_flag), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) en_seen <= bit_en;
  always @(negedge clk) if (rst_n && en_seen && tx_act) cap_q.push_back(tx_bit);

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push_entry(input logic [9:0] e);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = e;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  function automatic logic [31:0] poly_of(input int sel);
    if (sel == 0) return 32'h0000_8408;
    if (sel == 1) return 32'h0000_A001;
    return 32'hEDB8_8320;
  endfunction

  task automatic add_flag();
    for (int i = 0; i < 8; i++) exp_q.push_back(((8'h7E >> i) & 1) != 0);
  endtask

  task automatic build_exp(input int n, input int sel, input logic [31:0] init,
                           input bit framed, input bit with_fcs);
    logic [31:0] c;
    int ones;
    bit d;
    bit fb;
    body_q.delete();
    exp_q.delete();
    c = (sel < 2) ? {16'h0, init[15:0]} : init;
    for (int k = 0; k < n; k++) begin
      for (int i = 0; i < 8; i++) begin
        d = pay[k][i];
        body_q.push_back(d);
        fb = c[0] ^ d;
        c  = c >> 1;
        if (fb) c = c ^ poly_of(sel);
      end
    end
    if (with_fcs)
      for (int i = 0; i < ((sel < 2) ? 16 : 32); i++) body_q.push_back(~c[i]);
    if (!framed) begin
      foreach (body_q[i]) exp_q.push_back(body_q[i]);
    end else begin
      add_flag();
      ones = 0;
      foreach (body_q[i]) begin
        exp_q.push_back(body_q[i]);
        if (body_q[i]) begin
          ones++;
          if (ones == 5) begin
            exp_q.push_back(1'b0);
            ones = 0;
          end
        end else begin
          ones = 0;
        end
      end
      add_flag();
    end
  endtask

  task automatic run_bits(input int ncyc, input bit gaps);
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      bit_en = gaps ? ((i % 3) == 0) : 1'b1;
    end
    @(negedge clk);
    bit_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic compare_stream(input string req);
    int bad;
    bad = -1;
    if (cap_q.size() == exp_q.size()) begin
      foreach (exp_q[i]) if (bad < 0 && cap_q[i] != exp_q[i]) bad = i;
      check(bad < 0, req, bad, -1);
    end else begin
      check(1'b0, req, cap_q.size(), exp_q.size());
    end
  endtask

  // framed packet: optional untagged lead entry, begin on first, end on last if with_end
  task automatic framed_case(input int sel, input int n, input int seed,
                             input bit gaps, input bit with_end);
    logic [31:0] init;
    logic [9:0]  e;
    init = (seed % 2 == 0) ? 32'hFFFF_FFFF : 32'(seed * 32'h9E37_79B1);
    crc_sel  = 2'(sel);
    crc_init = init;
    raw_mode = 1'b0;
    for (int k = 0; k < n; k++)
      pay[k] = (seed % 4 == 3) ? 8'hFF : 8'(seed * 29 + k * 113 + k * k * 7 + 3);
    cap_q.delete();
    if (seed % 2 == 1) push_entry(10'h0A5);   // R3: no begin tag, must be dropped
    for (int k = 0; k < n; k++) begin
      e = {1'b0, (k == 0), pay[k]};
      if (with_end && k == n - 1) e[9] = 1'b1;
      push_entry(e);
    end
    build_exp(n, sel, init, 1'b1, with_end);
    run_bits(3 * exp_q.size() + 40, gaps);
    if (with_end) begin
      compare_stream($sformatf("R4 R5 R6 R7 frame sel=%0d n=%0d seed=%0d", sel, n, seed));
      check(udr_flag == 1'b0, "R8 no underrun on complete frame", udr_flag, 0);
    end else begin
      compare_stream($sformatf("R8 aborted frame n=%0d seed=%0d", n, seed));
      check(udr_flag == 1'b1, "R8 underrun set", udr_flag, 1);
      do_flush();
      check(udr_flag == 1'b0, "R2 flush clears underrun", udr_flag, 0);
    end
    check(fifo_empty == 1'b1, "R3 R4 queue drained", fifo_empty, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [5:0] thr;
    bit         expi;
    rst_n    = 1'b0;
    wr_en    = 1'b0;
    wr_data  = '0;
    flush    = 1'b0;
    raw_mode = 1'b0;
    bit_en   = 1'b0;
    crc_sel  = '0;
    crc_init = '1;
    irq_mask = '0;
    irq_thr  = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    check(fifo_count == 0 && fifo_empty && !fifo_full, "R12 queue empty", fifo_count, 0);
    check(!ovr_flag && !udr_flag, "R12 sticky flags clear", {ovr_flag, udr_flag}, 0);
    check(!tx_act && tx_bit, "R12 serial idle", {tx_act, tx_bit}, 1);

    // R3..R7 framed sweep over CRC choices and lengths; R10 with sparse strobes
    for (int sel = 0; sel < 4; sel++)
      for (int n = 1; n <= 5; n++)
        framed_case(sel, n, sel * 10 + n, (n == 2), 1'b1);
    framed_case(0, 3, 3, 1'b0, 1'b1);       // all-ones payload, stuffing R7
    framed_case(2, 4, 7, 1'b1, 1'b1);
    // R8 underrun
    framed_case(0, 2, 3, 1'b0, 1'b0);
    framed_case(1, 1, 4, 1'b0, 1'b0);
    framed_case(2, 3, 11, 1'b1, 1'b0);

    // R9 raw mode: tags ignored, no flags or stuffing
    raw_mode = 1'b1;
    cap_q.delete();
    pay[0] = 8'hFF; pay[1] = 8'h3C; pay[2] = 8'hFE;
    push_entry({2'b01, pay[0]});
    push_entry({2'b11, pay[1]});
    push_entry({2'b10, pay[2]});
    build_exp(3, 0, 32'h0, 1'b0, 1'b0);
    run_bits(60, 1'b0);
    compare_stream("R9 raw serialisation");
    check(udr_flag == 1'b0, "R9 raw empty gives no underrun", udr_flag, 0);
    raw_mode = 1'b0;

    // R1 R11 fill sweep with interrupt sources; R2 overrun
    do_flush();
    for (int c = 0; c <= DEPTH; c++) begin
      check(fifo_count == 6'(c), "R1 fill count", fifo_count, c);
      check(fifo_empty == (c == 0) && fifo_full == (c == DEPTH), "R1 empty/full",
            {fifo_empty, fifo_full}, {(c == 0), (c == DEPTH)});
      thr = 6'((c * 7 + 5) % 34);
      irq_thr = thr;
      for (int m = 0; m < 5; m++) begin
        irq_mask = 5'(1 << m);
        #1;
        case (m)
          0: expi = (c == 0);
          1: expi = (c != 0);
          2: expi = (c == DEPTH);
          3: expi = (c != DEPTH);
          default: expi = (c >= int'(thr));
        endcase
        check(irq == expi, $sformatf("R11 irq src %0d count %0d", m, c), irq, expi);
      end
      irq_mask = 5'b0;
      #1;
      check(irq == 1'b0, "R11 all masked", irq, 0);
      if (c < DEPTH) push_entry(10'(c));
    end
    check(ovr_flag == 1'b0, "R2 no overrun at exactly full", ovr_flag, 0);
    push_entry(10'h3FF);
    check(ovr_flag == 1'b1 && fifo_count == 6'(DEPTH), "R2 overrun on write when full",
          {ovr_flag, fifo_count}, {1'b1, 6'(DEPTH)});
    @(negedge clk);
    check(ovr_flag == 1'b1, "R2 overrun sticky", ovr_flag, 1);
    @(negedge clk);
    flush = 1'b1;
    wr_en = 1'b1;
    wr_data = 10'h155;
    @(negedge clk);
    flush = 1'b0;
    wr_en = 1'b0;
    check(fifo_count == 0 && !ovr_flag, "R2 flush wins over write", fifo_count, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule